// File: doc/BRIEF.md
# PWM Output Disable Protection Controller

This block sits next to a PWM timer and tells it when to take its outputs into their safe state. Each of four groups has its own disable line. A group's line rises when one of its enabled fault sources fires. The line stays up until software has acknowledged the fault. The timer alone decides which level its pins take while disabled; this block supplies only the per-group disable request.

A group has three fault sources. The first is an external trigger pin, which is asynchronous and is synchronised inside the block; it is detected either as a high level or as a rising edge. The second is a request from the timer. The third is a software stop bit. The timer request is built from three timer-side fault indications: a dead-time error, both outputs high at once, and both outputs low at once. Each of these has its own enable, and a 2-bit selector steers their combined request to exactly one group. The pin source and the timer source each set a sticky flag. Software reads and clears the flags over a simple synchronous register bus with one cycle of read latency.

Register map (8-bit data):
- Addresses 0 to 3 hold one group each. Bit 0 is the pin enable, bit 1 the timer enable, bit 2 the software stop, bit 3 the edge mode (1 = rising edge, 0 = level), bit 4 the pin flag and bit 5 the timer flag.
- Address 4 holds the timer side. Bit 0 enables dead-time error, bit 1 both-high, bit 2 both-low, and bits 5:4 are the group select.
- Addresses 5 to 7 are unmapped.

Top module: `odg_top`

## Requirements
- R1: After reset every register field reads 0, every disable line is low and read data is 0.
- R2: With the pin enable at 1 and level mode, a high external trigger pin sets that group's pin flag. The disable line rises two clock edges after the pin rises, because of the two-flop synchroniser. With the pin enable at 0 the pin sets no flag and raises no disable.
- R3: In edge mode only a rising edge of the synchronised pin sets the pin flag. A pin held high after its flag is cleared does not set the flag again.
- R4: A timer-side fault indication whose own enable (address 4, bits 0 to 2) is 1 raises the disable line and sets the timer flag only in the group chosen by the select (address 4, bits 5:4), and only if that group's timer enable is 1. Indications whose enable is 0 are ignored.
- R5: With a group's timer enable at 0, timer requests routed to that group set no flag and raise no disable.
- R6: Writing 1 to a group's software stop bit raises its disable line on the next cycle. Writing 0 releases the line if no flag is set.
- R7: Flags are sticky: a flag stays set after its cause goes away, and writing 1 to a flag bit leaves it set.
- R8: Writing 0 to a flag bit clears it only when its cause is not active in that cycle; while the cause is active the flag stays set.
- R9: The disable line is high in the same cycle that a flag's set condition is present, before the flag register has updated.
- R10: A read returns the addressed register on the cycle after the read strobe; unmapped addresses read 0 and ignore writes; read data holds between reads.
- R11: A disable line stays high while any flag or the software stop bit of its group is set, and it only falls after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rdEn |
| trigPin | input | 4 | External trigger pin per group (asynchronous) |
| deadTimeErr | input | 1 | Timer fault: dead-time error |
| bothHigh | input | 1 | Timer fault: both outputs high |
| bothLow | input | 1 | Timer fault: both outputs low |
| disableOut | output | 4 | Per-group disable request to the timer |

## Verification
The checks assume that the timer-side fault indications are synchronous to `clk`, that only the trigger pins are asynchronous, and that the bus carries at most one read or write per cycle with its address and data held for that cycle. The bench drives every input on the falling clock edge and issues bus operations one at a time. It holds a trigger pin steady for at least three cycles, so the synchroniser and the edge detector see clean transitions. The rule that a disable line falls only after a write relies on the fault sources being cleared only by software, so the stimulus never removes a disable line by any other path.

// File: rtl/odg_pkg.sv
package odg_pkg;
  localparam int NUM_GROUPS = 4;
  localparam int GSEL_W     = $clog2(NUM_GROUPS);
  localparam int CFG_ADDR   = NUM_GROUPS;
  localparam int GRP_W      = 6;

  // group register fields
  localparam int B_PIN_EN   = 0;
  localparam int B_TIM_EN   = 1;
  localparam int B_SW_STOP  = 2;
  localparam int B_EDGE     = 3;
  localparam int B_PIN_FLAG = 4;
  localparam int B_TIM_FLAG = 5;

  // timer-side register fields
  localparam int B_DTE_EN   = 0;
  localparam int B_HI_EN    = 1;
  localparam int B_LO_EN    = 2;
  localparam int B_GSEL_LO  = 4;
  localparam int REQ_SRC    = 3;

  typedef struct packed {
    logic [NUM_GROUPS-1:0] grpWr;
    logic                  cfgWr;
    logic                  rdStb;
  } strobe_t;
endpackage

// File: rtl/odg_ctrl.sv
module odg_ctrl
  import odg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  logic [NUM_GROUPS-1:0] grpHit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign grpHit[g] = (addr == ADDR_W'(g));
  end

  always_comb begin
    stb.grpWr = wrEn ? grpHit : '0;
    stb.cfgWr = wrEn && (addr == CFG_A);
    stb.rdStb = rdEn;
  end
endmodule

// File: rtl/odg_group.sv
module odg_group
  import odg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic [GRP_W-1:0] wdata,
  input  logic             trigPin,
  input  logic             timCause,
  output logic [GRP_W-1:0] regView,
  output logic             disableOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev, pinNow, pinCause;
  logic pinEn, timEn, swStop, edgeMode;
  logic pinFlag, timFlag;
  logic pinSet, timSet;
  logic pinClr, timClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], trigPin};
      pinPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinNow   = syncQ[SYNC_STAGES-1];
  assign pinCause = edgeMode ? (pinNow & ~pinPrev) : pinNow;
  assign pinSet   = pinEn & pinCause;
  assign timSet   = timEn & timCause;
  assign pinClr   = wrStb & ~wdata[B_PIN_FLAG];
  assign timClr   = wrStb & ~wdata[B_TIM_FLAG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinEn    <= 1'b0;
      timEn    <= 1'b0;
      swStop   <= 1'b0;
      edgeMode <= 1'b0;
      pinFlag  <= 1'b0;
      timFlag  <= 1'b0;
    end else begin
      if (wrStb) begin
        pinEn    <= wdata[B_PIN_EN];
        timEn    <= wdata[B_TIM_EN];
        swStop   <= wdata[B_SW_STOP];
        edgeMode <= wdata[B_EDGE];
      end
      pinFlag <= pinSet | (pinFlag & ~pinClr);
      timFlag <= timSet | (timFlag & ~timClr);
    end
  end

  always_comb begin
    regView              = '0;
    regView[B_PIN_EN]    = pinEn;
    regView[B_TIM_EN]    = timEn;
    regView[B_SW_STOP]   = swStop;
    regView[B_EDGE]      = edgeMode;
    regView[B_PIN_FLAG]  = pinFlag;
    regView[B_TIM_FLAG]  = timFlag;
  end

  assign disableOut = pinFlag | timFlag | swStop | pinSet | timSet;
endmodule

// File: rtl/odg_datapath.sv
module odg_datapath
  import odg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_GROUPS-1:0] trigPin,
  input  logic                  deadTimeErr,
  input  logic                  bothHigh,
  input  logic                  bothLow,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_GROUPS-1:0] disableOut
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] NG_A  = ADDR_W'(NUM_GROUPS);

  logic [REQ_SRC-1:0]    reqEn;
  logic [GSEL_W-1:0]     grpSel;
  logic                  timReq;
  logic [NUM_GROUPS-1:0] timCause;
  logic [GRP_W-1:0]      grpView [NUM_GROUPS];
  logic [DATA_W-1:0]     cfgView;
  logic [DATA_W-1:0]     rdNext;
  logic                  unusedWdata;

  assign unusedWdata = ^wdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqEn  <= '0;
      grpSel <= '0;
    end else if (stb.cfgWr) begin
      reqEn  <= wdata[REQ_SRC-1:0];
      grpSel <= wdata[B_GSEL_LO +: GSEL_W];
    end
  end

  assign timReq = |(reqEn & {bothLow, bothHigh, deadTimeErr});

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign timCause[g] = timReq && (grpSel == GSEL_W'(g));

    odg_group #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_grp (
      .clk        (clk),
      .rstN       (rstN),
      .wrStb      (stb.grpWr[g]),
      .wdata      (wdata[GRP_W-1:0]),
      .trigPin    (trigPin[g]),
      .timCause   (timCause[g]),
      .regView    (grpView[g]),
      .disableOut (disableOut[g])
    );
  end

  always_comb begin
    cfgView                           = '0;
    cfgView[REQ_SRC-1:0]              = reqEn;
    cfgView[B_GSEL_LO +: GSEL_W]      = grpSel;
  end

  always_comb begin
    rdNext = '0;
    if (addr < NG_A) begin
      rdNext[GRP_W-1:0] = grpView[addr[GSEL_W-1:0]];
    end else if (addr == CFG_A) begin
      rdNext = cfgView;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdStb) begin
      rdata <= rdNext;
    end
  end
endmodule

// File: rtl/odg_top.sv
module odg_top
  import odg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [NUM_GROUPS-1:0] trigPin,
  input  logic                  deadTimeErr,
  input  logic                  bothHigh,
  input  logic                  bothLow,
  output logic [NUM_GROUPS-1:0] disableOut
);
  strobe_t stb;

  odg_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .stb  (stb)
  );

  odg_datapath #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .addr        (addr),
    .wdata       (wdata),
    .trigPin     (trigPin),
    .deadTimeErr (deadTimeErr),
    .bothHigh    (bothHigh),
    .bothLow     (bothLow),
    .rdata       (rdata),
    .disableOut  (disableOut)
  );
endmodule

// File: rtl/odg_checker.sv
module odg_checker
  import odg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     wdata,
  input logic [DATA_W-1:0]     rdata,
  input logic [NUM_GROUPS-1:0] disableOut
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] NG_A  = ADDR_W'(NUM_GROUPS);

  // R1: outputs are clear one edge after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (disableOut == '0 && rdata == '0));

  // R6: a software stop write raises the addressed line next cycle
  a_r6_sw_stop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr < NG_A && wdata[B_SW_STOP]) |=> disableOut[$past(addr[GSEL_W-1:0])]);

  // R10: unmapped reads return zero
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr > CFG_A) |=> rdata == '0);

  // R10: read data holds between reads
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdata));

  // R11: a disable line can only fall after a bus write
  a_r11_no_silent_release: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((disableOut & $past(disableOut)) == $past(disableOut)));
endmodule

bind odg_top odg_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .disableOut (disableOut)
);

// File: tb/tb_odg_top.sv
`timescale 1ns/1ps
module tb_odg_top;
  localparam int NG = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NG-1:0] trigPin = '0;
  logic       deadTimeErr = 1'b0;
  logic       bothHigh = 1'b0;
  logic       bothLow = 1'b0;
  logic [NG-1:0] disableOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  odg_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trigPin(trigPin),
    .deadTimeErr(deadTimeErr), .bothHigh(bothHigh), .bothLow(bothLow),
    .disableOut(disableOut)
  );

  // en and req are {lo, hi, deadtime}
  typedef struct packed {
    logic [1:0] gsel;
    logic [2:0] en;
    logic [2:0] req;
    logic [3:0] expMask;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'b111, 3'b001, 4'b0001},
    '{2'd2, 3'b111, 3'b010, 4'b0100},
    '{2'd3, 3'b100, 3'b100, 4'b1000},
    '{2'd1, 3'b100, 3'b011, 4'b0000},
    '{2'd1, 3'b010, 3'b010, 4'b0010},
    '{2'd0, 3'b000, 3'b111, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 disable in reset", disableOut, 0);
    rstN = 1'b1;
    waitN(1);
    chk("R1 disable after reset", disableOut, 0);
    rd(3'd0, r); chk("R1 group0 reg", r, 8'h00);
    rd(3'd4, r); chk("R1 timer reg", r, 8'h00);

    // vector table: timer request routing (R4, R9, R7, R8)
    for (int g = 0; g < NG; g++) wr(3'(g), 8'h02);
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, {2'b00, VECS[i].gsel, 1'b0, VECS[i].en});
      @(negedge clk);
      {bothLow, bothHigh, deadTimeErr} = VECS[i].req;
      #1;
      chk("R4 R9 routed disable", disableOut, VECS[i].expMask);
      @(negedge clk);
      {bothLow, bothHigh, deadTimeErr} = 3'b000;
      #1;
      chk("R7 timer flag sticky", disableOut, VECS[i].expMask);
      for (int g = 0; g < NG; g++) wr(3'(g), 8'h02);
      #1;
      chk("R8 timer flags cleared", disableOut, 0);
    end
    wr(3'd4, 8'h00);
    for (int g = 0; g < NG; g++) wr(3'(g), 8'h00);

    // R2: level detection through synchroniser
    wr(3'd0, 8'h01);
    @(negedge clk); trigPin[0] = 1'b1;
    waitN(1); chk("R2 no disable after one edge", disableOut[0], 0);
    waitN(1); chk("R2 disable after two edges", disableOut[0], 1);
    @(negedge clk); trigPin[0] = 1'b0;
    waitN(4); chk("R7 pin flag sticky", disableOut[0], 1);
    rd(3'd0, r); chk("R10 R2 pin flag read", r, 8'h11);
    wr(3'd0, 8'h11);
    rd(3'd0, r); chk("R7 write one keeps flag", r, 8'h11);
    wr(3'd0, 8'h01);
    #1; chk("R8 flag cleared release", disableOut[0], 0);
    rd(3'd0, r); chk("R8 flag reads clear", r, 8'h01);

    // R8: clear blocked while level cause active
    @(negedge clk); trigPin[0] = 1'b1;
    waitN(3);
    wr(3'd0, 8'h01);
    rd(3'd0, r); chk("R8 clear blocked by active cause", r, 8'h11);
    @(negedge clk); trigPin[0] = 1'b0;
    waitN(3);
    wr(3'd0, 8'h01);
    #1; chk("R8 clear after cause gone", disableOut[0], 0);
    wr(3'd0, 8'h00);

    // R2: pin enable off
    wr(3'd1, 8'h00);
    @(negedge clk); trigPin[1] = 1'b1;
    waitN(4); chk("R2 masked pin no disable", disableOut[1], 0);
    rd(3'd1, r); chk("R2 masked pin no flag", r, 8'h00);
    @(negedge clk); trigPin[1] = 1'b0;

    // R3: edge mode
    wr(3'd2, 8'h09);
    @(negedge clk); trigPin[2] = 1'b1;
    waitN(1); chk("R3 edge not yet", disableOut[2], 0);
    waitN(1); chk("R3 R9 edge disable same cycle", disableOut[2], 1);
    waitN(1); chk("R3 edge flag held", disableOut[2], 1);
    wr(3'd2, 8'h09);
    rd(3'd2, r); chk("R3 held high no reset of flag", r, 8'h09);
    #1; chk("R3 released while high", disableOut[2], 0);
    @(negedge clk); trigPin[2] = 1'b0;
    waitN(3);
    @(negedge clk); trigPin[2] = 1'b1;
    waitN(3);
    rd(3'd2, r); chk("R3 second edge sets flag", r, 8'h19);
    wr(3'd2, 8'h00);
    @(negedge clk); trigPin[2] = 1'b0;

    // R6 and R11: software stop with pin flag
    wr(3'd3, 8'h04);
    #1; chk("R6 sw stop asserts", disableOut[3], 1);
    rd(3'd3, r); chk("R6 sw stop reads", r, 8'h04);
    wr(3'd3, 8'h05);
    @(negedge clk); trigPin[3] = 1'b1;
    waitN(3);
    @(negedge clk); trigPin[3] = 1'b0;
    waitN(3);
    wr(3'd3, 8'h04);
    #1; chk("R11 sw stop holds disable", disableOut[3], 1);
    rd(3'd3, r); chk("R11 flag cleared stop kept", r, 8'h04);
    wr(3'd3, 8'h00);
    #1; chk("R6 sw stop released", disableOut[3], 0);

    // R5: timer enable off
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h00);
    @(negedge clk); deadTimeErr = 1'b1;
    #1; chk("R5 timer enable off no disable", disableOut[0], 0);
    @(negedge clk); deadTimeErr = 1'b0;
    rd(3'd0, r); chk("R5 no timer flag", r, 8'h00);
    rd(3'd4, r); chk("R10 timer reg read", r, 8'h01);

    // R10: unmapped address
    wr(3'd5, 8'hFF);
    rd(3'd5, r); chk("R10 unmapped reads zero", r, 8'h00);
    #1; chk("R10 unmapped write no effect", disableOut, 0);
    rd(3'd4, r); chk("R10 timer reg untouched", r, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule